// File: doc/BRIEF.md
# Peripheral Write-Phase Controller with Post-Write Request Masking

This block is the destination side of one hardware-paced DMA channel that feeds a peripheral of fixed data width. Bytes read from the source arrive one per cycle on a fill port and are packed into a staging register, lowest lane first. When the staging register holds one peripheral-width unit (one, two or four bytes), the block presents a write: the current destination address, the packed data and a transfer-size code. It holds the write until the completion signal that belongs to the destination arrives. For an on-chip destination that signal is the bus ready. For an off-chip destination it is the memory controller's acknowledge.

After each completed write the block loads a programmable wait-state count. While that count runs it gates off the peripheral's request line and refuses new fill bytes, so that the peripheral has time to withdraw its request before another transfer can start. The destination address advances by the unit size after every write. For FIFO-style targets a hold setting freezes it instead. Software seeds the address with a load strobe.

Top module: `pwh_top`

## Requirements
- R1: After reset, wr_valid is 0, fill_ready is 1, wr_addr is 0 and req_out follows periph_req.
- R2: wr_valid rises in the cycle after the clock edge that accepts the last byte of a unit. A unit is 1 byte for cfg_width 0, 2 bytes for 1 and 4 bytes for 2. wr_valid stays 0 while fewer bytes are staged, and once high it stays high with a stable address and data until completion.
- R3: While wr_valid is 1, wr_size equals the width code: 0 for byte, 1 for half-word, 2 for word.
- R4: wr_data carries the first staged byte in bits 7:0, the second in bits 15:8, and so on. Lanes beyond the unit size read 0.
- R5: With cfg_ext = 0, a write completes on the edge where bus_ready is 1, and ext_ack has no effect.
- R6: With cfg_ext = 1, a write completes on the edge where ext_ack is 1, and bus_ready has no effect.
- R7: After a completion with cfg_wait = N > 0, req_out is 0 for exactly N cycles. It then follows periph_req again.
- R8: With cfg_wait = 0, the cycle after completion already has fill_ready = 1 and req_out equal to periph_req.
- R9: With cfg_hold = 1, wr_addr is unchanged by a completed write.
- R10: With cfg_hold = 0, wr_addr increases by 1, 2 or 4 (the unit size) after each completed write.
- R11: fill_ready is 0 during a write and during the wait count. Bytes offered then are discarded and do not appear in the next unit.
- R12: An addr_load pulse makes wr_addr equal to addr_val from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_width | input | 2 | Peripheral width code: 0 byte, 1 half-word, 2 word |
| cfg_hold | input | 1 | 1 freezes the destination address |
| cfg_ext | input | 1 | 1 selects off-chip acknowledge as completion, 0 selects bus ready |
| cfg_wait | input | WW (4) | Post-write wait-state count |
| addr_load | input | 1 | Load strobe for the destination address |
| addr_val | input | AW (32) | Value loaded by addr_load |
| fill_valid | input | 1 | A source byte is offered |
| fill_byte | input | 8 | Offered byte |
| fill_ready | output | 1 | Byte is accepted on this edge when fill_valid is 1 |
| periph_req | input | 1 | Raw peripheral request |
| req_out | output | 1 | Request after masking |
| wr_valid | output | 1 | Write in progress |
| wr_addr | output | AW (32) | Current destination address |
| wr_size | output | 2 | Transfer-size code |
| wr_data | output | DW (32) | Packed write data |
| bus_ready | input | 1 | On-chip write completion |
| ext_ack | input | 1 | Off-chip memory controller acknowledge |

## Verification
The assertions take for granted that cfg_width, cfg_hold, cfg_ext and cfg_wait stay constant from the first byte of a unit until its wait count expires. They also assume that addr_load is pulsed only while no write is pending. The stimulus changes the configuration only in the fill state with the staging register empty, draws width codes from 0 to 2 only, and issues address loads between transfers. While a write or wait count is in progress, the bench deliberately asserts the completion signal that does not belong to the destination and offers junk bytes. This shows that both are ignored.

// File: rtl/pwh_pkg.sv
package pwh_pkg;

  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_WRITE = 2'd1,
    ST_WAIT  = 2'd2
  } pwh_state_e;

  // Number of bytes in one peripheral unit; codes above word act as word.
  function automatic logic [2:0] unit_bytes(input logic [1:0] width);
    case (width)
      2'd0:    unit_bytes = 3'd1;
      2'd1:    unit_bytes = 3'd2;
      default: unit_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] size_code(input logic [1:0] width);
    size_code = (width == 2'd3) ? 2'd2 : width;
  endfunction

endpackage

// File: rtl/pwh_rst_sync.sv
module pwh_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/pwh_stage.sv
module pwh_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    push_byte,
  input  logic          clr,
  input  logic [2:0]    need,
  output logic          last_push,
  output logic [DW-1:0] data
);

  localparam int LANES = DW / 8;
  localparam int CW    = $clog2(LANES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [7:0]    lane_q [LANES];

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (push) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic lane_we;
    assign lane_we = push && (cnt_q == CW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q[g] <= 8'h00;
      end else if (clr) begin
        lane_q[g] <= 8'h00;
      end else if (lane_we) begin
        lane_q[g] <= push_byte;
      end
    end

    assign data[g*8 +: 8] = lane_q[g];
  end

  assign last_push = push && ((cnt_q + 1'b1) == CW'(need));

  AST_STAGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(need)) else $error("staging count beyond unit size"); // R2

  AST_STAGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && (data == '0)) else $error("staging not cleared"); // R11

endmodule

// File: rtl/pwh_addr.sv
module pwh_addr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic          hold,
  input  logic [1:0]    width,
  output logic [AW-1:0] addr
);

  import pwh_pkg::*;

  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (load) begin
      addr_d = load_val;
    end else if (step && !hold) begin
      addr_d = addr_q + AW'(unit_bytes(width));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else begin
      addr_q <= addr_d;
    end
  end

  assign addr = addr_q;

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && hold && !load) |=> $stable(addr_q)) else $error("held address moved"); // R9

  AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !hold && !load) |=> (addr_q != $past(addr_q))) else $error("address did not advance"); // R10

  AST_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(addr_q)) else $error("address moved without a write"); // R10

endmodule

// File: rtl/pwh_wait.sv
module pwh_wait #(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [WW-1:0] count_val,
  output logic          busy,
  output logic          last
);

  logic [WW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = count_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == WW'(1));

  AST_WAIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !start) |=> !busy) else $error("wait count overran"); // R7

  AST_WAIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy) else $error("wait count restarted by itself"); // R8

endmodule

// File: rtl/pwh_top.sv
module pwh_top #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_width,
  input  logic          cfg_hold,
  input  logic          cfg_ext,
  input  logic [WW-1:0] cfg_wait,
  input  logic          addr_load,
  input  logic [AW-1:0] addr_val,
  input  logic          fill_valid,
  input  logic [7:0]    fill_byte,
  output logic          fill_ready,
  input  logic          periph_req,
  output logic          req_out,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [1:0]    wr_size,
  output logic [DW-1:0] wr_data,
  input  logic          bus_ready,
  input  logic          ext_ack
);

  import pwh_pkg::*;

  logic       rst_s_n;
  pwh_state_e state_q, state_d;
  logic       push, last_push, done, confirm;
  logic       wait_busy, wait_last;
  logic [2:0] need;

  pwh_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_s_n)
  );

  assign need       = unit_bytes(cfg_width);
  assign fill_ready = (state_q == ST_FILL);
  assign push       = fill_valid && fill_ready;
  assign confirm    = cfg_ext ? ext_ack : bus_ready;
  assign done       = (state_q == ST_WRITE) && confirm;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_FILL:  if (last_push) state_d = ST_WRITE;
      ST_WRITE: if (done)      state_d = (cfg_wait != '0) ? ST_WAIT : ST_FILL;
      ST_WAIT:  if (wait_last) state_d = ST_FILL;
      default:                 state_d = ST_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_FILL;
    end else begin
      state_q <= state_d;
    end
  end

  pwh_stage #(.DW(DW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .push      (push),
    .push_byte (fill_byte),
    .clr       (done),
    .need      (need),
    .last_push (last_push),
    .data      (wr_data)
  );

  pwh_addr #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load     (addr_load),
    .load_val (addr_val),
    .step     (done),
    .hold     (cfg_hold),
    .width    (cfg_width),
    .addr     (wr_addr)
  );

  pwh_wait #(.WW(WW)) u_wait (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .start     (done),
    .count_val (cfg_wait),
    .busy      (wait_busy),
    .last      (wait_last)
  );

  assign wr_valid = (state_q == ST_WRITE);
  assign wr_size  = size_code(cfg_width);
  assign req_out  = periph_req && (state_q != ST_WAIT);

  AST_WRITE_STEADY: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_valid && !confirm) |=> wr_valid && $stable(wr_data)) else $error("write dropped early"); // R2

  AST_NO_FILL_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_s_n)
    wait_busy |-> !fill_ready) else $error("fill accepted during wait"); // R11

  AST_WAIT_MASKS: assert property (@(posedge clk) disable iff (!rst_s_n)
    wait_busy |-> !req_out) else $error("request not masked"); // R7

  AST_START_WRITE: assert property (@(posedge clk) disable iff (!rst_s_n)
    last_push |=> wr_valid) else $error("write did not start on full unit"); // R2

endmodule

// File: tb/pwh_top_tb.sv
module pwh_top_tb;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    cfg_width;
  logic          cfg_hold, cfg_ext;
  logic [WW-1:0] cfg_wait;
  logic          addr_load;
  logic [AW-1:0] addr_val;
  logic          fill_valid;
  logic [7:0]    fill_byte;
  logic          fill_ready;
  logic          periph_req, req_out;
  logic          wr_valid;
  logic [AW-1:0] wr_addr;
  logic [1:0]    wr_size;
  logic [DW-1:0] wr_data;
  logic          bus_ready, ext_ack;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;
  logic [AW-1:0] exp_addr;

  always #2 clk = ~clk;

  pwh_top #(.AW(AW), .DW(DW), .WW(WW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_hold(cfg_hold),
    .cfg_ext(cfg_ext), .cfg_wait(cfg_wait), .addr_load(addr_load),
    .addr_val(addr_val), .fill_valid(fill_valid), .fill_byte(fill_byte),
    .fill_ready(fill_ready), .periph_req(periph_req), .req_out(req_out),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_size(wr_size),
    .wr_data(wr_data), .bus_ready(bus_ready), .ext_ack(ext_ack)
  );

  function automatic int unit_of(input logic [1:0] w);
    return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic load_addr(input logic [AW-1:0] a);
    addr_load = 1'b1;
    addr_val  = a;
    @(negedge clk);
    addr_load = 1'b0;
    exp_addr  = a;
    chk("R12 address load", wr_addr, a);
  endtask

  task automatic xfer(input logic [1:0] w, input bit hold, input bit ext,
                      input int wt, input int lat);
    int n;
    logic [DW-1:0] exp_data;
    cfg_width = w;
    cfg_hold  = hold;
    cfg_ext   = ext;
    cfg_wait  = WW'(wt);
    n = unit_of(w);
    exp_data = '0;
    for (int i = 0; i < n; i++) begin
      int gap;
      gap = $urandom_range(0, 2);
      for (int j = 0; j < gap; j++) begin
        @(negedge clk);
        chk("R2 no write on partial unit", wr_valid, 1'b0);
      end
      fill_valid = 1'b1;
      fill_byte  = 8'($urandom);
      exp_data[i*8 +: 8] = fill_byte;
      @(negedge clk);
      fill_valid = 1'b0;
      chk("R2 write starts on full unit", wr_valid, (i == n - 1));
    end
    chk("R3 size code", wr_size, w);
    chk("R4 packed data", wr_data, exp_data);
    // Junk bytes and the wrong completion signal while the write pends.
    fill_valid = 1'b1;
    fill_byte  = 8'hEE;
    for (int k = 0; k < lat; k++) begin
      if (ext) bus_ready = 1'b1; else ext_ack = 1'b1;
      @(negedge clk);
      chk(ext ? "R6 bus_ready ignored" : "R5 ext_ack ignored", wr_valid, 1'b1);
      chk("R11 fill refused in write", fill_ready, 1'b0);
    end
    bus_ready = ext ? 1'b0 : 1'b1;
    ext_ack   = ext ? 1'b1 : 1'b0;
    @(negedge clk);
    bus_ready = 1'b0;
    ext_ack   = 1'b0;
    chk(ext ? "R6 ack completes" : "R5 ready completes", wr_valid, 1'b0);
    if (!hold) exp_addr = exp_addr + AW'(n);
    chk(hold ? "R9 address held" : "R10 address step", wr_addr, exp_addr);
    if (wt == 0) begin
      chk("R8 no mask cycles", req_out, 1'b1);
      chk("R8 fill ready at once", fill_ready, 1'b1);
      fill_valid = 1'b0;
    end else begin
      for (int k = 0; k < wt; k++) begin
        chk("R7 request masked", req_out, 1'b0);
        chk("R11 fill refused in wait", fill_ready, 1'b0);
        @(negedge clk);
      end
      chk("R7 mask released", req_out, 1'b1);
      chk("R7 fill ready after wait", fill_ready, 1'b1);
      fill_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed_init;
    seed_init = $urandom(32'h5EED_0042);
    rst_n = 1'b0;
    cfg_width = 2'd0; cfg_hold = 1'b0; cfg_ext = 1'b0; cfg_wait = '0;
    addr_load = 1'b0; addr_val = '0;
    fill_valid = 1'b0; fill_byte = 8'h00;
    periph_req = 1'b0; bus_ready = 1'b0; ext_ack = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 wr_valid in reset", wr_valid, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 wr_valid after reset", wr_valid, 1'b0);
    chk("R1 fill_ready after reset", fill_ready, 1'b1);
    chk("R1 address after reset", wr_addr, '0);
    chk("R1 req_out follows low", req_out, 1'b0);
    periph_req = 1'b1;
    #1;
    chk("R1 req_out follows high", req_out, 1'b1);
    @(negedge clk);
    load_addr(32'h1000_0000);

    // Directed corners.
    xfer(2'd0, 1'b0, 1'b0, 0, 0);
    xfer(2'd1, 1'b0, 1'b1, 1, 2);
    xfer(2'd2, 1'b1, 1'b0, 3, 1);
    xfer(2'd2, 1'b1, 1'b1, 0, 3);
    xfer(2'd1, 1'b1, 1'b0, 15, 0);
    xfer(2'd2, 1'b0, 1'b1, 2, 0);
    load_addr(32'hFFFF_FFFE);
    xfer(2'd1, 1'b0, 1'b0, 1, 1);

    // Random mix.
    for (int t = 0; t < 120; t++) begin
      if (t % 30 == 0) load_addr(32'($urandom));
      xfer(2'($urandom_range(0, 2)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), $urandom_range(0, 5), $urandom_range(0, 3));
    end

    @(negedge clk);
    finish_run();
  end

endmodule